// File: doc/BRIEF.md
# Paged Circular Event Buffer Writer

This block collects the digitized words of one event into a circular memory made of fixed-size pages, one event per page. An event opens when the digitizer signals that its rundown has ended. While the event is open, each incoming word carries a channel tag, and the block keeps the word only if its value is above the threshold programmed for that channel. Kept words are written one after another into the current page, starting at the second slot. The first slot is kept free for a header.

When the conversion-done strobe arrives, the capture flag drops and the block writes the header into slot zero of the page. The header is the absolute memory address just past the last kept word. Its upper bits therefore name the page, and its lower bits give the event's word count, header included. The write page then moves to the next page, wrapping around after the last one. An event with no kept words still gets a header, with a count of one.

A fast clear that arrives inside a programmable window after the event opens throws the event away. In that case no header is written and the page does not advance. The block compares its write page with the reader's page to detect a full ring, and it refuses new events while the ring is full.

Top module: `event_page_writer`

## Requirements
- R1: After reset, busy is 0, wr_page is 0, mem_we is 0, every channel threshold is 0 and the fast-clear window length is 0.
- R2: A rundown_done pulse while the block is idle and not full opens an event: busy is 1 from the next cycle on.
- R3: While busy, a word with in_valid set is written only if in_data is strictly greater than the threshold of in_chan. It is written at address {wr_page, offset}, with data {in_chan, in_data} (channel in the upper 6 bits). The offset starts at 1 for each event and increases by one per written word.
- R4: conv_done while busy makes busy 0 in the next cycle. In that same cycle the block writes the header at address {wr_page, 0}, with value {wr_page, next free offset} zero-extended. A word that arrives in the conv_done cycle is still kept.
- R5: An event with no kept words writes a header whose 7-bit count field is 1.
- R6: wr_page increases by one, modulo 8, on the clock edge that ends the header cycle, and at no other time.
- R7: Let L be the window length. A fast_clear in any of the first L busy cycles of an event discards the event. busy drops, no header is written, wr_page is unchanged, and the next event starts again at offset 1. A word arriving in the discard cycle is not written.
- R8: A fast_clear after the window has closed, or while the block is not busy, has no effect.
- R9: full is 1 exactly when (wr_page + 1) mod 8 equals rd_page. A rundown_done while full does not open an event.
- R10: An event keeps at most 126 data words (offsets 1 to 126). Further words are dropped, and the header count is then 127.
- R11: Threshold and window-length loads take effect from the next cycle. A rundown_done while busy or during the header cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rundown_done | input | 1 | End of digitizer rundown; opens an event |
| in_valid | input | 1 | Digitized word present |
| in_chan | input | 6 | Channel tag of the word |
| in_data | input | 12 | Digitized value |
| conv_done | input | 1 | All words of the event have been delivered |
| fast_clear | input | 1 | Request to discard the current event |
| rd_page | input | 3 | Page the reader is on |
| thr_we | input | 1 | Load a channel threshold |
| thr_chan | input | 6 | Channel whose threshold is loaded |
| thr_val | input | 12 | Threshold value |
| win_we | input | 1 | Load the fast-clear window length |
| win_len | input | 8 | Window length in cycles |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 10 | Memory address {page, offset} |
| mem_wdata | output | 18 | Memory write data |
| wr_page | output | 3 | Current write page |
| busy | output | 1 | Event capture in progress |
| full | output | 1 | Ring full; new events refused |

## Verification
Some properties are checked by assertions on every cycle. A header goes only to slot zero and only right after busy falls. wr_page only ever moves up by one, and only after a header write. Data writes always land on the current page, inside offsets 1 to 126. busy rises only after rundown_done, and never when the ring was full. Other behaviour shows only in the bench's scenarios, which compare every cycle against a behavioural model: threshold filtering per channel, the exact count in each header, the edges of the fast-clear window, ignored fast clears and rundowns, page overflow, and the wrap of wr_page from 7 to 0.

// File: rtl/evb_pkg.sv
package evb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CAPT = 2'd1,
      ST_HDR  = 2'd2
   } evb_state_e;
endpackage

// File: rtl/evb_thresh_table.sv
module evb_thresh_table #(
   parameter int CHAN_W    = 6,
   parameter int DATA_W    = 12,
   parameter bit INCLUSIVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_we,
   input  logic [CHAN_W-1:0] ld_chan,
   input  logic [DATA_W-1:0] ld_val,
   input  logic [CHAN_W-1:0] q_chan,
   input  logic [DATA_W-1:0] q_data,
   output logic              q_pass
);
   localparam int NCH = 1 << CHAN_W;

   logic [DATA_W-1:0] thr_q [NCH];
   logic [DATA_W-1:0] lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) thr_q[i] <= '0;
      end else if (ld_we) begin
         thr_q[ld_chan] <= ld_val;
      end
   end

   assign lim = thr_q[q_chan];

   generate
      if (INCLUSIVE) begin : g_ge
         assign q_pass = (q_data >= lim);
      end else begin : g_gt
         assign q_pass = (q_data > lim);
      end
   endgenerate
endmodule

// File: rtl/evb_fc_window.sv
module evb_fc_window #(
   parameter int WIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_we,
   input  logic [WIN_W-1:0] len_val,
   input  logic             arm,
   output logic             open
);
   logic [WIN_W-1:0] len_q;
   logic [WIN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
      end else if (len_we) begin
         len_q <= len_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (arm) begin
         cnt_q <= len_q;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign open = (cnt_q != '0);
endmodule

// File: rtl/evb_page_ptr.sv
module evb_page_ptr #(
   parameter int PAGE_W = 3,
   parameter int OFS_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              store,
   input  logic              commit,
   input  logic              abort,
   input  logic [PAGE_W-1:0] rd_page,
   output logic [PAGE_W-1:0] wr_page,
   output logic [OFS_W-1:0]  ofs,
   output logic              room,
   output logic              full
);
   localparam logic [OFS_W-1:0]  OFS_LAST  = '1;
   localparam logic [OFS_W-1:0]  OFS_FIRST = OFS_W'(1);
   localparam logic [PAGE_W-1:0] PAGE_ONE  = PAGE_W'(1);

   logic [PAGE_W-1:0] page_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [PAGE_W-1:0] page_next;

   assign page_next = page_q + PAGE_ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q <= '0;
      end else if (arm) begin
         ofs_q <= OFS_FIRST;
      end else if (abort || commit) begin
         ofs_q <= '0;
      end else if (store) begin
         ofs_q <= ofs_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (commit) begin
         page_q <= page_next;
      end
   end

   assign wr_page = page_q;
   assign ofs     = ofs_q;
   assign room    = (ofs_q != OFS_LAST);
   assign full    = (page_next == rd_page);
endmodule

// File: rtl/event_page_writer.sv
module event_page_writer
   import evb_pkg::*;
#(
   parameter int DATA_W        = 12,
   parameter int CHAN_W        = 6,
   parameter int PAGE_W        = 3,
   parameter int OFS_W         = 7,
   parameter int WIN_W         = 8,
   parameter bit THR_INCLUSIVE = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rundown_done,
   input  logic                      in_valid,
   input  logic [CHAN_W-1:0]         in_chan,
   input  logic [DATA_W-1:0]         in_data,
   input  logic                      conv_done,
   input  logic                      fast_clear,
   input  logic [PAGE_W-1:0]         rd_page,
   input  logic                      thr_we,
   input  logic [CHAN_W-1:0]         thr_chan,
   input  logic [DATA_W-1:0]         thr_val,
   input  logic                      win_we,
   input  logic [WIN_W-1:0]          win_len,
   output logic                      mem_we,
   output logic [PAGE_W+OFS_W-1:0]   mem_addr,
   output logic [CHAN_W+DATA_W-1:0]  mem_wdata,
   output logic [PAGE_W-1:0]         wr_page,
   output logic                      busy,
   output logic                      full
);
   localparam int ADDR_W = PAGE_W + OFS_W;
   localparam int WORD_W = CHAN_W + DATA_W;

   generate
      if (WORD_W < ADDR_W) begin : g_bad_word
         $error("memory word too narrow to hold a header address");
      end
      if (OFS_W < 2) begin : g_bad_ofs
         $error("page must hold a header and at least one data word");
      end
      if (PAGE_W < 1) begin : g_bad_page
         $error("ring needs at least two pages");
      end
      if (WIN_W < 1) begin : g_bad_win
         $error("window length needs at least one bit");
      end
   endgenerate

   evb_state_e state_q, state_d;

   logic              in_capt, in_hdr;
   logic              arm, abort, store, finish;
   logic              pass, room, fc_open, full_i;
   logic [OFS_W-1:0]  ofs;
   logic [PAGE_W-1:0] page;

   evb_thresh_table #(
      .CHAN_W    (CHAN_W),
      .DATA_W    (DATA_W),
      .INCLUSIVE (THR_INCLUSIVE)
   ) u_thr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_we   (thr_we),
      .ld_chan (thr_chan),
      .ld_val  (thr_val),
      .q_chan  (in_chan),
      .q_data  (in_data),
      .q_pass  (pass)
   );

   evb_fc_window #(
      .WIN_W (WIN_W)
   ) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .len_we  (win_we),
      .len_val (win_len),
      .arm     (arm),
      .open    (fc_open)
   );

   evb_page_ptr #(
      .PAGE_W (PAGE_W),
      .OFS_W  (OFS_W)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm),
      .store   (store),
      .commit  (in_hdr),
      .abort   (abort),
      .rd_page (rd_page),
      .wr_page (page),
      .ofs     (ofs),
      .room    (room),
      .full    (full_i)
   );

   assign in_capt = (state_q == ST_CAPT);
   assign in_hdr  = (state_q == ST_HDR);

   assign arm    = (state_q == ST_IDLE) && rundown_done && !full_i;
   assign abort  = in_capt && fast_clear && fc_open;
   assign store  = in_capt && in_valid && pass && room && !abort;
   assign finish = in_capt && conv_done && !abort;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (arm) state_d = ST_CAPT;
         ST_CAPT: begin
            if (abort)       state_d = ST_IDLE;
            else if (finish) state_d = ST_HDR;
         end
         ST_HDR:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign mem_we    = store || in_hdr;
   assign mem_addr  = in_hdr ? {page, {OFS_W{1'b0}}} : {page, ofs};
   assign mem_wdata = in_hdr ? WORD_W'({page, ofs}) : {in_chan, in_data};
   assign wr_page   = page;
   assign busy      = in_capt;
   assign full      = full_i;
endmodule

// File: rtl/evb_writer_chk.sv
module evb_writer_chk #(
   parameter int PAGE_W = 3,
   parameter int OFS_W  = 7
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    rundown_done,
   input logic                    mem_we,
   input logic [PAGE_W+OFS_W-1:0] mem_addr,
   input logic [PAGE_W-1:0]       wr_page,
   input logic                    busy,
   input logic                    full
);
   localparam int ADDR_W = PAGE_W + OFS_W;
   localparam logic [OFS_W-1:0] OFS_LAST = '1;

   logic [OFS_W-1:0]  a_ofs;
   logic [PAGE_W-1:0] a_page;
   assign a_ofs  = mem_addr[OFS_W-1:0];
   assign a_page = mem_addr[ADDR_W-1:OFS_W];

   AST_BUSY_NEEDS_RUNDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(rundown_done)); // R2

   AST_DATA_ON_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (a_page == wr_page)); // R3

   AST_DATA_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && busy) |-> (a_ofs != '0 && a_ofs != OFS_LAST)); // R10

   AST_HDR_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && a_ofs == '0) |-> (!busy && $past(busy))); // R4

   AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_page != $past(wr_page)) |->
         (wr_page == $past(wr_page) + 1'b1 && $past(mem_we) && $past(a_ofs) == '0)); // R6

   AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && full && rundown_done) |=> !busy); // R9
endmodule

bind event_page_writer evb_writer_chk #(
   .PAGE_W (PAGE_W),
   .OFS_W  (OFS_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rundown_done (rundown_done),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr),
   .wr_page      (wr_page),
   .busy         (busy),
   .full         (full)
);

// File: tb/test_event_page_writer.sv
`timescale 1ns/1ps
module test_event_page_writer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        rundown_done, in_valid, conv_done, fast_clear;
   logic [5:0]  in_chan, thr_chan;
   logic [11:0] in_data, thr_val;
   logic [2:0]  rd_page;
   logic        thr_we, win_we;
   logic [7:0]  win_len;
   logic        mem_we;
   logic [9:0]  mem_addr;
   logic [17:0] mem_wdata;
   logic [2:0]  wr_page;
   logic        busy, full;

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   event_page_writer i_event_page_writer (
      .clk(clk), .rst_n(rst_n), .rundown_done(rundown_done), .in_valid(in_valid),
      .in_chan(in_chan), .in_data(in_data), .conv_done(conv_done),
      .fast_clear(fast_clear), .rd_page(rd_page), .thr_we(thr_we),
      .thr_chan(thr_chan), .thr_val(thr_val), .win_we(win_we), .win_len(win_len),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .wr_page(wr_page), .busy(busy), .full(full));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference model: 0 idle, 1 capturing, 2 header
   int m_state = 0, m_page = 0, m_ofs = 0, m_win = 0, m_len = 0;
   int m_thr [64];
   int last_hdr = -1, hdr_cnt = 0, last_dat_addr = -1;

   always @(negedge clk) begin
      if (rst_n) begin
         int e_we, e_addr, e_dat, e_full;
         e_full = (((m_page + 1) % 8) == rd_page);
         e_we = 0; e_addr = 0; e_dat = 0;
         if (m_state == 1) begin
            bit ab;
            ab = fast_clear && (m_win > 0);
            if (in_valid && (in_data > m_thr[in_chan]) && m_ofs < 127 && !ab) begin
               e_we = 1; e_addr = m_page * 128 + m_ofs; e_dat = in_chan * 4096 + in_data;
            end
         end else if (m_state == 2) begin
            e_we = 1; e_addr = m_page * 128; e_dat = m_page * 128 + m_ofs;
         end
         chk(busy == (m_state == 1), "R2 busy", busy, m_state == 1);
         chk(wr_page == m_page, "R6 wr_page", wr_page, m_page);
         chk(full == e_full, "R9 full", full, e_full);
         chk(mem_we == e_we, "R3 mem_we", mem_we, e_we);
         if (e_we) begin
            chk(mem_addr == e_addr, "R3 mem_addr", mem_addr, e_addr);
            chk(mem_wdata == e_dat, "R4 mem_wdata", mem_wdata, e_dat);
         end
         if (mem_we && mem_addr[6:0] == 0) begin
            last_hdr = mem_wdata; hdr_cnt++;
         end else if (mem_we) begin
            last_dat_addr = mem_addr;
         end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_page = 0; m_ofs = 0; m_win = 0; m_len = 0;
         foreach (m_thr[i]) m_thr[i] = 0;
      end else begin
         bit e_full;
         e_full = (((m_page + 1) % 8) == rd_page);
         case (m_state)
            0: begin
               if (m_win > 0) m_win--;
               if (rundown_done && !e_full) begin
                  m_state = 1; m_ofs = 1; m_win = m_len;
               end
            end
            1: begin
               bit ab;
               ab = fast_clear && (m_win > 0);
               if (m_win > 0) m_win--;
               if (ab) begin
                  m_state = 0; m_ofs = 0;
               end else begin
                  if (in_valid && (in_data > m_thr[in_chan]) && m_ofs < 127) m_ofs++;
                  if (conv_done) m_state = 2;
               end
            end
            default: begin
               if (m_win > 0) m_win--;
               m_state = 0; m_ofs = 0; m_page = (m_page + 1) % 8;
            end
         endcase
         if (thr_we) m_thr[thr_chan] = thr_val;
         if (win_we) m_len = win_len;
      end
   end

   task automatic step(input bit v, input int ch, input int d, input bit rd,
                       input bit cd, input bit fc);
      in_valid = v; in_chan = 6'(ch); in_data = 12'(d);
      rundown_done = rd; conv_done = cd; fast_clear = fc;
      @(posedge clk); #1;
      in_valid = 0; rundown_done = 0; conv_done = 0; fast_clear = 0;
      thr_we = 0; win_we = 0;
   endtask

   task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

   task automatic null_event();
      step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 1, 0); idle();
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int h0;
      rst_n = 0; rundown_done = 0; in_valid = 0; in_chan = 0; in_data = 0;
      conv_done = 0; fast_clear = 0; rd_page = 0; thr_we = 0; thr_chan = 0;
      thr_val = 0; win_we = 0; win_len = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #1;
      chk(busy == 0 && wr_page == 0 && mem_we == 0 && full == 0, "R1 reset state",
          {busy, wr_page, mem_we, full}, 0);
      idle();

      thr_we = 1; thr_chan = 3; thr_val = 100; idle();
      win_we = 1; win_len = 4; idle();

      // R3/R4: filtered capture, last word kept with conv_done
      step(0, 0, 0, 1, 0, 0);
      step(1, 3, 50, 0, 0, 0);
      step(1, 3, 150, 0, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      step(1, 1, 7, 0, 1, 0);
      idle();
      chk(last_hdr == 3, "R4 header page0 count3", last_hdr, 3);
      chk(wr_page == 1, "R6 page after header", wr_page, 1);

      // R5: null event
      null_event();
      chk(last_hdr == 129, "R5 null header", last_hdr, 129);

      // R7: fast clear inside window
      h0 = hdr_cnt;
      step(0, 0, 0, 1, 0, 0);
      step(1, 1, 9, 0, 0, 0);
      step(1, 1, 9, 0, 0, 1);
      idle();
      chk(busy == 0 && wr_page == 2 && hdr_cnt == h0, "R7 discard", hdr_cnt, h0);
      step(0, 0, 0, 1, 0, 0);
      step(1, 1, 11, 0, 0, 0);
      chk(last_dat_addr == 257, "R7 restart at offset 1", last_dat_addr, 257);
      step(0, 0, 0, 0, 1, 0);
      idle();
      chk(last_hdr == 258, "R7 header after restart", last_hdr, 258);

      // R8: fast clear after the window closed, and while idle
      step(0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 1, 0, 0);
      repeat (5) idle();
      step(0, 0, 0, 0, 0, 1);
      step(1, 2, 4, 0, 1, 0);
      idle();
      chk(last_hdr == 386 && wr_page == 4, "R8 late fast clear ignored", last_hdr, 386);

      // R11: rundown while busy ignored; threshold load next cycle
      step(0, 0, 0, 1, 0, 0);
      step(1, 2, 4, 0, 0, 0);
      step(0, 0, 0, 1, 0, 0);
      step(1, 2, 5, 0, 0, 0);
      step(0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 1, 0, 0);
      chk(busy == 0, "R11 rundown in header cycle ignored", busy, 0);
      chk(last_hdr == 515, "R11 rundown while busy ignored", last_hdr, 515);
      thr_we = 1; thr_chan = 2; thr_val = 200; idle();
      step(0, 0, 0, 1, 0, 0);
      step(1, 2, 150, 0, 0, 0);
      step(1, 2, 201, 0, 1, 0);
      idle();
      chk(last_hdr == 642, "R11 new threshold applied", last_hdr, 642);

      // R10: page overflow
      step(0, 0, 0, 1, 0, 0);
      for (int i = 0; i < 130; i++) step(1, 1, 5, 0, 0, 0);
      step(0, 0, 0, 0, 1, 0);
      idle();
      chk(last_hdr == 6 * 128 + 127, "R10 overflow count", last_hdr, 6 * 128 + 127);

      // R9: full refuses events
      chk(full == 1, "R9 full at page 7 with reader at 0", full, 1);
      h0 = hdr_cnt;
      step(0, 0, 0, 1, 0, 0);
      chk(busy == 0, "R9 rundown refused", busy, 0);
      step(0, 0, 0, 0, 1, 0);
      idle();
      chk(hdr_cnt == h0 && wr_page == 7, "R9 no header when refused", hdr_cnt, h0);

      // R6: wrap around
      rd_page = 7; idle();
      null_event();
      chk(wr_page == 0 && last_hdr == 7 * 128 + 1, "R6 wrap 7 to 0", wr_page, 0);
      for (int i = 0; i < 6; i++) null_event();
      chk(wr_page == 6 && full == 1, "R9 full after lap", wr_page, 6);

      repeat (3) idle();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule